// File: doc/BRIEF.md
# Write-Only I2C Command Target

This block is an I2C target for a chip that only takes commands from the bus. A fast system clock samples SCL and SDA through two-flop synchronizers, and the block finds START, repeated START and STOP conditions in the sampled lines. It answers one 7-bit address: the upper five bits are fixed at `01100` and the lower two come from strap inputs. It pulls SDA low through an open-drain enable to acknowledge each byte it accepts.

A transaction has three bytes: the address byte with a write flag, a command byte, and a data byte. The last two form a 16-bit command word. The word goes to the command register bank with a one-cycle strobe on the rising edge of the 26th SCL pulse, which is the last data bit. A transaction cut short before that pulse changes nothing. A repeated START opens a new address phase, so several writes can be chained without a STOP.

The controlling state machine has these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`, `ST_CMD` and `ST_DATA`: a byte is being shifted in.
- `ST_ACK_ADDR`, `ST_ACK_CMD` and `ST_ACK_DATA`: the acknowledge is being driven.
- `ST_IGNORE`: the block stays off the bus until the next START.

Its transitions are:
- START from any state goes to `ST_ADDR`.
- A STOP that is honoured goes to `ST_IDLE`.
- After the SCL fall that ends bit 8, `ST_ADDR` goes to `ST_ACK_ADDR` when the address matches and the write flag is set. Otherwise it goes to `ST_IGNORE`.
- After the SCL fall that ends bit 8, `ST_CMD` goes to `ST_ACK_CMD` and `ST_DATA` goes to `ST_ACK_DATA`.
- After the SCL fall that ends the ninth pulse, each ACK state moves on: `ST_ACK_ADDR` to `ST_CMD`, `ST_ACK_CMD` to `ST_DATA`, and `ST_ACK_DATA` to `ST_IGNORE`.

Top module: `i2c_wr_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `cmd_valid` is 0 and `cmd_word` is 0x0000.
- R2: An address byte of `0 1 1 0 0 strap_a[1] strap_a[0] 0` (MSB first) is acknowledged. `sda_oe` rises after the SCL fall that ends bit 8 and falls after the SCL fall that ends the ninth pulse.
- R3: An address byte whose upper seven bits differ from `{01100, strap_a}` gets no acknowledge and causes no strobe.
- R4: An address byte with the R/W bit (bit 0) at 1 gets no acknowledge. The following bytes get no acknowledge and cause no strobe until the next START.
- R5: After an accepted address, the command byte and the data byte are each acknowledged on their ninth clock.
- R6: `cmd_word[15:8]` is the command byte and `cmd_word[7:0]` is the data byte, both MSB first. `cmd_valid` pulses for exactly one cycle. The pulse comes 3 clock cycles after SCL rises for the 26th pulse of the transaction.
- R7: A STOP before the 26th SCL pulse ends the transaction with no strobe, and `cmd_word` keeps its previous value.
- R8: A repeated START starts a new address phase. Two writes chained by a repeated START give two strobes, and the second word is held afterwards.
- R9: A STOP in the same SCL high period as the START before it is ignored, and the transaction goes on.
- R10: Bytes after the data byte of a transaction get no acknowledge and cause no further strobe.
- R11: Changing `strap_a` changes the matched address. The old address is no longer acknowledged and the new one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| strap_a | input | 2 | Low two address bits from strap pins |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| cmd_word | output | 16 | Last committed command word |
| cmd_valid | output | 1 | One-cycle strobe when `cmd_word` is updated |

## Verification
Every bus edge reaches the state machine two clock cycles after the pin changes, because it passes through the synchronizer. The cycle after that, the edge comparison sees it. So `cmd_valid` and a new `cmd_word` appear 3 cycles after the 26th SCL rise, and `sda_oe` changes 3 cycles after the SCL fall that moves it.

The bench holds each SCL quarter-period for 10 clock cycles. It reads the acknowledge enable 10 cycles after each fall and again in the middle of the high phase, well after the 3-cycle latency. A monitor records the cycle of each strobe, and the bench requires it to be exactly 3 cycles after the SCL rise it recorded.

// File: rtl/i2cwt_pkg.sv
package i2cwt_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [4:0] ADDR_HI = 5'b01100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_DATA,
        ST_ACK_DATA,
        ST_IGNORE
    } wt_state_e;
endpackage

// File: rtl/i2cwt_sync.sv
module i2cwt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '1;
                end else if (s == 0) begin
                    chain[s] <= din;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cwt_cond.sv
module i2cwt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q, start_hold;
    logic stop_raw;

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_raw  = scl_s & scl_q & ~sda_q & sda_s;
    // a stop within the high period that carried the start is not honoured
    assign stop_evt  = stop_raw & ~start_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            start_hold <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            if (start_evt) begin
                start_hold <= 1'b1;
            end else if (scl_fall) begin
                start_hold <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2cwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_a,
    output logic              sda_oe,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_valid
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0] sync_q;
    logic scl_s, sda_s;
    logic scl_rise_w, scl_fall_w, start_w, stop_ok_w;

    wt_state_e st, st_nxt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] cmd_byte;
    logic [CNT_W-1:0]  bitcnt;
    logic byte_st, ack_st, byte_done;

    i2cwt_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    i2cwt_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise_w),
        .scl_fall (scl_fall_w),
        .start_evt(start_w),
        .stop_evt (stop_ok_w)
    );

    assign byte_st   = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_DATA);
    assign ack_st    = (st == ST_ACK_ADDR) || (st == ST_ACK_CMD) || (st == ST_ACK_DATA);
    assign byte_done = scl_fall_w && (bitcnt == CNT_FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        if (start_w) begin
            st_nxt = ST_ADDR;
        end else if (stop_ok_w) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_nxt = ST_IDLE;
                ST_IGNORE:   st_nxt = ST_IGNORE;
                ST_ADDR:
                    if (byte_done) begin
                        st_nxt = (shreg[BYTE_W-1:1] == {ADDR_HI, strap_a} && !shreg[0])
                                 ? ST_ACK_ADDR : ST_IGNORE;
                    end
                ST_CMD:      if (byte_done)  st_nxt = ST_ACK_CMD;
                ST_DATA:     if (byte_done)  st_nxt = ST_ACK_DATA;
                ST_ACK_ADDR: if (scl_fall_w) st_nxt = ST_CMD;
                ST_ACK_CMD:  if (scl_fall_w) st_nxt = ST_DATA;
                ST_ACK_DATA: if (scl_fall_w) st_nxt = ST_IGNORE;
            endcase
        end
    end

    // outputs and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            cmd_byte  <= '0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
            sda_oe    <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            sda_oe    <= (st_nxt == ST_ACK_ADDR) || (st_nxt == ST_ACK_CMD) ||
                         (st_nxt == ST_ACK_DATA);
            if (start_w || (ack_st && scl_fall_w)) begin
                bitcnt <= '0;
            end else if (byte_st && scl_rise_w && bitcnt != CNT_FULL) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (st == ST_CMD && byte_done && !start_w && !stop_ok_w) begin
                cmd_byte <= shreg;
            end
            if (st == ST_DATA && scl_rise_w && bitcnt == CNT_LAST) begin
                cmd_valid <= 1'b1;
                cmd_word  <= {cmd_byte, shreg[BYTE_W-2:0], sda_s};
            end
        end
    end
endmodule

// File: rtl/i2cwt_checker.sv
module i2cwt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic        scl_rise_w,
    input logic        scl_fall_w,
    input logic        start_w,
    input logic        stop_ok_w
);
    // R2: the acknowledge enable only moves after an SCL fall or a bus condition
    assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall_w || start_w || stop_ok_w));

    // R6: the strobe lasts a single cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: the strobe follows an SCL rising edge
    assert_strobe_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(scl_rise_w));

    // R7: the word changes only together with the strobe
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_word) |-> cmd_valid);

    // R2: no acknowledge is driven in the cycle a bus condition is seen
    assert_oe_quiet_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> !sda_oe);
endmodule

bind i2c_wr_target i2cwt_checker u_i2cwt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .scl_rise_w(scl_rise_w),
    .scl_fall_w(scl_fall_w),
    .start_w   (start_w),
    .stop_ok_w (stop_ok_w)
);

// File: tb/test_i2c_wr_target.sv
`timescale 1ns/1ps
module test_i2c_wr_target;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic [1:0]  strap_a = 2'b10;
    logic        sda_oe;
    logic [15:0] cmd_word;
    logic        cmd_valid;
    wire         sda_bus = sda_drv & ~sda_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_rise = 0;
    int strobes  = 0;
    int strobe_delta = 0;
    logic [15:0] strobe_word = '0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_wr_target i_i2c_wr_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_bus),
        .strap_a  (strap_a),
        .sda_oe   (sda_oe),
        .cmd_word (cmd_word),
        .cmd_valid(cmd_valid)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            strobes      <= strobes + 1;
            strobe_delta <= cyc - last_rise;
            strobe_word  <= cmd_word;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sda_drv = b;
        wait_clk(Q);
        scl_drv = 1'b1;
        last_rise = cyc;
        wait_clk(2 * Q);
        scl_drv = 1'b0;
        wait_clk(Q);
    endtask

    task automatic do_start();
        @(negedge clk);
        sda_drv = 1'b1;
        wait_clk(Q);
        scl_drv = 1'b1;
        wait_clk(Q);
        sda_drv = 1'b0;
        wait_clk(Q);
        scl_drv = 1'b0;
        wait_clk(Q);
    endtask

    task automatic do_stop();
        @(negedge clk);
        sda_drv = 1'b0;
        wait_clk(Q);
        scl_drv = 1'b1;
        wait_clk(Q);
        sda_drv = 1'b1;
        wait_clk(2 * Q);
    endtask

    // sends a byte and clocks the ninth pulse; returns 1 when acknowledged
    task automatic send_byte(input logic [7:0] b, output bit acked, output bit released);
        bit early;
        bit held;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        @(negedge clk);
        sda_drv = 1'b1;
        wait_clk(Q);
        early = sda_oe && !sda_bus;
        scl_drv = 1'b1;
        last_rise = cyc;
        wait_clk(Q);
        held = !sda_bus;
        wait_clk(Q);
        scl_drv = 1'b0;
        wait_clk(Q);
        released = !sda_oe;
        acked = early && held;
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rw);
        return {5'b01100, s, rw};
    endfunction

    task automatic t_reset();
        wait_clk(2);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        check(cmd_word == 16'h0000, "R1 cmd_word", cmd_word, 0);
    endtask

    task automatic write3(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                          output bit ka, output bit kc, output bit kd, output bit rel);
        bit r1, r2, r3;
        send_byte(a, ka, r1);
        send_byte(c, kc, r2);
        send_byte(d, kd, r3);
        rel = r1 && r2 && r3;
    endtask

    task automatic t_write(input logic [1:0] s, input logic [15:0] w, input string tag);
        bit ka, kc, kd, rel;
        int s0;
        strap_a = s;
        s0 = strobes;
        do_start();
        write3(addr_byte(s, 1'b0), w[15:8], w[7:0], ka, kc, kd, rel);
        do_stop();
        check(ka, {tag, " R2 address ack"}, ka, 1);
        check(rel, {tag, " R2 ack release"}, rel, 1);
        check(kc && kd, {tag, " R5 byte acks"}, {kc, kd}, 3);
        check(strobes == s0 + 1, {tag, " R6 strobe count"}, strobes - s0, 1);
        check(strobe_word == w, {tag, " R6 word"}, strobe_word, w);
        check(strobe_delta == 3, {tag, " R6 strobe latency"}, strobe_delta, 3);
        check(cmd_word == w, {tag, " R6 held word"}, cmd_word, w);
    endtask

    task automatic t_wrong_addr();
        bit ka, kc, kd, rel;
        int s0 = strobes;
        logic [15:0] w0 = cmd_word;
        strap_a = 2'b10;
        do_start();
        write3(addr_byte(2'b11, 1'b0), 8'h12, 8'h34, ka, kc, kd, rel);
        do_stop();
        check(!ka, "R3 no address ack", ka, 0);
        check(strobes == s0 && cmd_word == w0, "R3 no strobe", cmd_word, w0);
    endtask

    task automatic t_read();
        bit ka, kc, kd, rel;
        int s0 = strobes;
        logic [15:0] w0 = cmd_word;
        do_start();
        write3(addr_byte(strap_a, 1'b1), 8'h55, 8'hAA, ka, kc, kd, rel);
        do_stop();
        check(!ka, "R4 read not acked", ka, 0);
        check(!kc && !kd, "R4 later bytes ignored", {kc, kd}, 0);
        check(strobes == s0 && cmd_word == w0, "R4 no strobe", cmd_word, w0);
    endtask

    task automatic t_abort();
        bit ka, kc, r;
        int s0 = strobes;
        logic [15:0] w0 = cmd_word;
        do_start();
        send_byte(addr_byte(strap_a, 1'b0), ka, r);
        send_byte(8'h3C, kc, r);
        do_stop();
        check(strobes == s0 && cmd_word == w0, "R7 stop after command byte", cmd_word, w0);
        do_start();
        send_byte(addr_byte(strap_a, 1'b0), ka, r);
        send_byte(8'h3C, kc, r);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        do_stop();
        check(strobes == s0 && cmd_word == w0, "R7 stop inside data byte", cmd_word, w0);
    endtask

    task automatic t_chain();
        bit ka, kc, kd, rel, ka2, kc2, kd2, rel2;
        int s0 = strobes;
        do_start();
        write3(addr_byte(strap_a, 1'b0), 8'h0A, 8'hB1, ka, kc, kd, rel);
        do_start();
        write3(addr_byte(strap_a, 1'b0), 8'hC2, 8'hD3, ka2, kc2, kd2, rel2);
        do_stop();
        check(ka && kc && kd && ka2 && kc2 && kd2, "R8 all acked", {ka2, kc2, kd2}, 7);
        check(strobes == s0 + 2, "R8 two strobes", strobes - s0, 2);
        check(cmd_word == 16'hC2D3, "R8 second word held", cmd_word, 16'hC2D3);
    endtask

    task automatic t_early_stop();
        bit ka, kc, kd, rel;
        int s0 = strobes;
        @(negedge clk);
        sda_drv = 1'b1;
        wait_clk(Q);
        scl_drv = 1'b1;
        wait_clk(Q);
        sda_drv = 1'b0;
        wait_clk(Q);
        sda_drv = 1'b1;
        wait_clk(Q);
        scl_drv = 1'b0;
        wait_clk(Q);
        write3(addr_byte(strap_a, 1'b0), 8'h5E, 8'h71, ka, kc, kd, rel);
        do_stop();
        check(ka, "R9 transaction continues", ka, 1);
        check(strobes == s0 + 1 && cmd_word == 16'h5E71, "R9 word", cmd_word, 16'h5E71);
    endtask

    task automatic t_extra_byte();
        bit ka, kc, kd, rel, kx, rx;
        int s0 = strobes;
        do_start();
        write3(addr_byte(strap_a, 1'b0), 8'h44, 8'h88, ka, kc, kd, rel);
        send_byte(8'h99, kx, rx);
        do_stop();
        check(!kx, "R10 fourth byte not acked", kx, 0);
        check(strobes == s0 + 1 && cmd_word == 16'h4488, "R10 single strobe", strobes - s0, 1);
    endtask

    task automatic t_strap();
        bit ka, r;
        strap_a = 2'b01;
        do_start();
        send_byte(addr_byte(2'b10, 1'b0), ka, r);
        do_stop();
        check(!ka, "R11 old address refused", ka, 0);
        do_start();
        send_byte(addr_byte(2'b01, 1'b0), ka, r);
        do_stop();
        check(ka, "R11 new address acked", ka, 1);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write(2'b10, 16'h1ABC, "w1");
        t_write(2'b01, 16'hFFFF, "w2");
        t_write(2'b00, 16'h0000, "w3");
        t_wrong_addr();
        t_read();
        t_abort();
        t_chain();
        t_early_stop();
        t_extra_byte();
        t_strap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule